// File: doc/BRIEF.md
# Receive FIFO Inactivity Watchdog

This block sits beside one serial receiver and tells the host that received characters are waiting in the receive FIFO and nobody has collected them. When a message ends with fewer characters than the FIFO fill level that raises the normal receive interrupt, nothing else would tell the host about those leftover bytes. The watchdog fills that gap.

The watchdog counts serial bit times, not clock cycles. It takes a one-cycle bit-time tick from the baud generator. Two events restart the count: a character moving from the shift register into the FIFO, and a host read of the FIFO. If 64 bit times pass with no restart while the FIFO holds data, a sticky time-out flag is raised. The interrupt request is that flag gated by a per-receiver enable. A receiver reset clears the counter and the flag.

Top module: `rx_fifo_watchdog`

## Requirements
- R1: With the FIFO non-empty and no restart event, `timeout_flag` rises on the clock edge that samples the 64th `bit_tick` after the last restart. After 63 ticks the flag is still low.
- R2: A cycle with `rx_push` high restarts the count from zero. The same edge clears `timeout_flag`.
- R3: A cycle with `host_pop` high restarts the count from zero. The same edge clears `timeout_flag`. A read after 63 ticks therefore prevents the expiry that the next tick would have caused.
- R4: When a restart event and a `bit_tick` fall in the same cycle, the restart wins and that tick is not counted.
- R5: While `fifo_nonempty` is low, the counter is held at zero and no expiry can occur. Counting begins again from zero once the FIFO holds data.
- R6: Once set, `timeout_flag` stays high through any number of further ticks until a restart event or a receiver reset. The counter saturates at 64 and never exceeds it.
- R7: `irq_req` equals `timeout_flag` AND `irq_en`, combinationally. Changing `irq_en` never alters `timeout_flag`.
- R8: A cycle with `rx_reset` high clears the counter and `timeout_flag` on that edge. It takes priority over every other input.
- R9: After the asynchronous active-low `rst_n`, `timeout_flag` and `irq_req` are low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| rx_push | input | 1 | Character moved from shift register into the FIFO |
| host_pop | input | 1 | Host read of the receive FIFO |
| fifo_nonempty | input | 1 | FIFO holds at least one character |
| rx_reset | input | 1 | Synchronous receiver reset |
| irq_en | input | 1 | Interrupt enable for this receiver |
| timeout_flag | output | 1 | Sticky time-out status |
| irq_req | output | 1 | Masked interrupt request |

## Verification
`timeout_flag` is a register. It changes on the edge that samples the 64th tick, a push, a pop, or a receiver reset. `irq_req` follows `timeout_flag` and `irq_en` in the same cycle with no added delay.

The bench drives every input at a falling edge and holds it for one full cycle. It samples at the next falling edge, which is half a period after the edge that updates the flag. Each tick takes two cycles, so every count lands on a known edge. The bench counts ticks itself and never reads the internal counter.

// File: rtl/rxwd_pkg.sv
package rxwd_pkg;
  // Saturating advance of the bit-time count: moves by one on a tick, stops at lim.
  function automatic int unsigned wd_step(input int unsigned cur, input logic tick,
                                          input int unsigned lim);
    if (tick && cur < lim) return cur + 1;
    return cur;
  endfunction

  // True when this tick is the one that reaches the limit.
  function automatic logic wd_hits(input int unsigned cur, input logic tick,
                                   input int unsigned lim);
    return tick && (cur == lim - 1);
  endfunction
endpackage

// File: rtl/rxwd_events.sv
module rxwd_events (
  input  logic rx_push,
  input  logic host_pop,
  input  logic rx_reset,
  output logic restart,
  output logic clear
);
  // A push or a pop starts the count over; a receiver reset clears as well.
  assign restart = rx_push | host_pop;
  assign clear   = restart | rx_reset;
endmodule

// File: rtl/rxwd_counter.sv
module rxwd_counter import rxwd_pkg::*; #(
  parameter int unsigned LIMIT = 64,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             clear,
  input  logic             fifo_nonempty,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = fifo_nonempty && !clear && wd_hits(int'(count), bit_tick, LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear)          count <= '0;
    else if (!fifo_nonempty) count <= '0;
    else                     count <= CNT_W'(wd_step(int'(count), bit_tick, LIMIT));
  end

  assert_empty_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nonempty |=> count == '0);
  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= LIMIT);
  assert_tick_ignored_on_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && bit_tick) |-> !expire);
endmodule

// File: rtl/rxwd_status.sv
module rxwd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic expire,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (clear)  flag <= 1'b0;
    else if (expire) flag <= 1'b1;
  end

  assert_expire_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !flag);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> flag);
endmodule

// File: rtl/rx_fifo_watchdog.sv
module rx_fifo_watchdog #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_push,
  input  logic host_pop,
  input  logic fifo_nonempty,
  input  logic rx_reset,
  input  logic irq_en,
  output logic timeout_flag,
  output logic irq_req
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic             restart;
  logic             clear;
  logic             expire;
  logic [CNT_W-1:0] count;

  rxwd_events u_events (
    .rx_push  (rx_push),
    .host_pop (host_pop),
    .rx_reset (rx_reset),
    .restart  (restart),
    .clear    (clear)
  );

  rxwd_counter #(.LIMIT(LIMIT)) u_counter (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .clear         (clear),
    .fifo_nonempty (fifo_nonempty),
    .count         (count),
    .expire        (expire)
  );

  rxwd_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .expire (expire),
    .flag   (timeout_flag)
  );

  assign irq_req = timeout_flag & irq_en;

  assert_rx_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!timeout_flag && count == '0));
  assert_push_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !rx_reset) |=> (count == '0 && !timeout_flag));
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);
endmodule

// File: tb/rx_fifo_watchdog_bench.sv
module rx_fifo_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  typedef struct packed {
    logic [7:0] pre;   // ticks before the event
    logic [1:0] ev;    // 0 none, 1 push, 2 pop
    logic [7:0] post;  // ticks after the event
    logic       ne;
    logic       en;
    logic       ef;    // expected flag
    logic       ei;    // expected irq
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd64, 2'd0, 8'd0,  1'b1, 1'b1, 1'b1, 1'b1},  // R1 expiry on 64th
    '{8'd63, 2'd0, 8'd0,  1'b1, 1'b1, 1'b0, 1'b0},  // R1 not at 63
    '{8'd63, 2'd2, 8'd1,  1'b1, 1'b1, 1'b0, 1'b0},  // R3 pop at 63 prevents
    '{8'd63, 2'd1, 8'd1,  1'b1, 1'b1, 1'b0, 1'b0},  // R2 push at 63 prevents
    '{8'd63, 2'd2, 8'd64, 1'b1, 1'b1, 1'b1, 1'b1},  // R3 expiry 64 after pop
    '{8'd64, 2'd0, 8'd0,  1'b1, 1'b0, 1'b1, 1'b0},  // R7 masked
    '{8'd100,2'd0, 8'd0,  1'b0, 1'b1, 1'b0, 1'b0},  // R5 empty never expires
    '{8'd90, 2'd0, 8'd0,  1'b1, 1'b1, 1'b1, 1'b1},  // R6 sticky past limit
    '{8'd64, 2'd2, 8'd0,  1'b1, 1'b1, 1'b0, 1'b0},  // R3 pop clears flag
    '{8'd64, 2'd1, 8'd0,  1'b1, 1'b1, 1'b0, 1'b0}   // R2 push clears flag
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, rx_push = 1'b0, host_pop = 1'b0;
  logic fifo_nonempty = 1'b0, rx_reset = 1'b0, irq_en = 1'b0;
  logic timeout_flag, irq_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_watchdog u_rx_fifo_watchdog (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_push(rx_push),
    .host_pop(host_pop), .fifo_nonempty(fifo_nonempty), .rx_reset(rx_reset),
    .irq_en(irq_en), .timeout_flag(timeout_flag), .irq_req(irq_req)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
  endtask

  task automatic pulse(input logic [1:0] kind);
    @(negedge clk);
    rx_push  = (kind == 2'd1);
    host_pop = (kind == 2'd2);
    @(negedge clk);
    rx_push = 1'b0; host_pop = 1'b0;
  endtask

  task automatic rx_rst();
    @(negedge clk) rx_reset = 1'b1;
    @(negedge clk) rx_reset = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(timeout_flag, 1'b0, "R9 flag after reset");
    check(irq_req, 1'b0, "R9 irq after reset");
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      rx_rst();
      fifo_nonempty = VECS[v].ne;
      irq_en = VECS[v].en;
      ticks(int'(VECS[v].pre));
      if (VECS[v].ev != 2'd0) pulse(VECS[v].ev);
      ticks(int'(VECS[v].post));
      check(timeout_flag, VECS[v].ef, $sformatf("R1 R2 R3 R5 R6 vector %0d flag", v));
      check(irq_req, VECS[v].ei, $sformatf("R7 vector %0d irq", v));
    end

    // R1 flag due on the very edge of the 64th tick
    rx_rst(); fifo_nonempty = 1'b1; irq_en = 1'b1;
    ticks(63);
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    check(timeout_flag, 1'b1, "R1 flag one cycle after 64th tick");

    // R7 enable changes only irq, combinationally
    irq_en = 1'b0; #1;
    check(irq_req, 1'b0, "R7 irq drops with enable");
    check(timeout_flag, 1'b1, "R7 flag unaffected by enable");
    irq_en = 1'b1; #1;
    check(irq_req, 1'b1, "R7 irq returns with enable");

    // R8 receiver reset clears set flag
    rx_rst();
    check(timeout_flag, 1'b0, "R8 reset clears flag");
    check(irq_req, 1'b0, "R8 reset clears irq");

    // R8 reset mid-count restarts the count; reset beats a simultaneous tick
    ticks(63);
    @(negedge clk) begin rx_reset = 1'b1; bit_tick = 1'b1; end
    @(negedge clk) begin rx_reset = 1'b0; bit_tick = 1'b0; end
    check(timeout_flag, 1'b0, "R8 reset beats tick");
    ticks(63);
    check(timeout_flag, 1'b0, "R8 count restarted by reset");
    ticks(1);
    check(timeout_flag, 1'b1, "R8 expiry 64 ticks after reset");

    // R4 pop coinciding with the 64th tick wins
    rx_rst(); ticks(63);
    @(negedge clk) begin host_pop = 1'b1; bit_tick = 1'b1; end
    @(negedge clk) begin host_pop = 1'b0; bit_tick = 1'b0; end
    check(timeout_flag, 1'b0, "R4 restart beats tick");
    ticks(63);
    check(timeout_flag, 1'b0, "R4 tick not counted, 63 after");
    ticks(1);
    check(timeout_flag, 1'b1, "R4 expiry 64 after restart");

    // R5 empty FIFO resets the count mid-way
    rx_rst(); ticks(40);
    @(negedge clk) fifo_nonempty = 1'b0;
    @(negedge clk) fifo_nonempty = 1'b1;
    ticks(24);
    check(timeout_flag, 1'b0, "R5 empty restarted count");
    ticks(39);
    check(timeout_flag, 1'b0, "R5 63 ticks after empty");
    ticks(1);
    check(timeout_flag, 1'b1, "R5 expiry 64 after refill");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule